// File: doc/BRIEF.md
# Parallel Ramp-Compare Conversion Controller

This block handles the digital side of a ramp-compare analogue-to-digital conversion that is spread across many storage cells. A start request with a bank mask opens one pass. The block then raises the ramp enable for the analogue ramp generator and runs one shared Gray-coded counter. Every cell of every selected bank watches its own comparator output. On the first rising edge of that comparator during the pass, the cell stores the counter value present at that moment. All selected cells are therefore digitised together in a single sweep of the counter.

When the counter has covered its full range, the ramp enable drops and a done pulse follows. A cell whose comparator never rose during the pass is given the maximum code and an overflow flag. Stored Gray codes are turned into plain binary before they leave the block. Cells in banks left out of the mask keep their old results, so later extraction can read banks from different passes.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset, ramp_en, done, every code_bin field, every ovf bit and gray_cnt are all zero.
- R2: A start accepted while idle sets ramp_en high from the next cycle. It then stays high for exactly 2^CNT_W cycles. In the n-th of those cycles (n counted from 0), gray_cnt equals n ^ (n >> 1).
- R3: While ramp_en stays high, each new value of gray_cnt differs from the previous value in exactly one bit.
- R4: ramp_en falls on the edge where the count wraps from its maximum back to zero. done is high for exactly one cycle, the second cycle after ramp_en falls, and gray_cnt rests at zero while idle.
- R5: start is ignored while ramp_en is high and during the one cycle between ramp_en falling and done rising. Such a start changes neither the pass timing nor the bank selection.
- R6: Cell i belongs to bank i / CELLS_PER_BANK and reports at code_bin[i*CNT_W +: CNT_W]. Suppose its bank is selected and its comparator is low at one edge and high at the next edge, during the ramp cycle whose count is n. The cell's code then becomes binary n with ovf[i] low.
- R7: After a cell has captured a value, later comparator edges in the same pass leave its code unchanged.
- R8: A selected cell whose comparator shows no rising edge during the pass ends with code 2^CNT_W-1 and ovf[i] high.
- R9: The code and ovf of cells in unselected banks keep their previous values through a pass, whatever their comparators do.
- R10: Starting a pass clears the code and ovf of every selected cell to zero. The code stays zero until that cell captures.
- R11: A rising edge during the last count (2^CNT_W-1) is a normal capture: the code is 2^CNT_W-1 and ovf stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Conversion pass request |
| bank_sel | input | NBANK | Banks to convert in this pass |
| cmp_in | input | NBANK*CELLS_PER_BANK | Comparator output per cell |
| ramp_en | output | 1 | Enables the analogue ramp |
| done | output | 1 | One-cycle pulse after a pass |
| gray_cnt | output | CNT_W | Shared Gray count broadcast to the cells |
| code_bin | output | NBANK*CELLS_PER_BANK*CNT_W | Captured codes, binary, cell i in field i |
| ovf | output | NBANK*CELLS_PER_BANK | Per-cell flag for a comparator that never fired |

## Verification
The bench drives comparator edges at the very first and the very last count. A design with an off-by-one capture register would report these as one code higher, and would wrongly flag a last-count edge as an overflow. Each comparator pulses and then rises again later in the same pass, so a cell that re-arms would return the later count. The comparators of unselected banks also toggle, so a design that leaks the mask would overwrite their retained codes. Starts are issued in the middle of a ramp and in the gap before done. A design that accepts either would restart the counter or pick up the new mask, and the ramp, done and Gray-count timing would then go wrong.

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
  parameter int CNT_W          = 10,
  parameter int NBANK          = 4,
  parameter int CELLS_PER_BANK = 4,
  localparam int NCELLS        = NBANK * CELLS_PER_BANK
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NBANK-1:0]         bank_sel,
  input  logic [NCELLS-1:0]        cmp_in,
  output logic                     ramp_en,
  output logic                     done,
  output logic [CNT_W-1:0]         gray_cnt,
  output logic [NCELLS*CNT_W-1:0]  code_bin,
  output logic [NCELLS-1:0]        ovf
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] g2b(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int k = CNT_W-2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [CNT_W-1:0]  cnt_bin;
  logic              fin;
  logic [NCELLS-1:0] cmp_q;
  logic [NCELLS-1:0] armed;
  logic [CNT_W-1:0]  code_g [NCELLS];

  wire accept = start && !ramp_en && !fin;
  wire wrap   = ramp_en && (cnt_bin == TOP);
  wire [NCELLS-1:0] rise = cmp_in & ~cmp_q;

  assign gray_cnt = cnt_bin ^ (cnt_bin >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_bin <= '0;
      ramp_en <= 1'b0;
      fin     <= 1'b0;
      done    <= 1'b0;
      cmp_q   <= '0;
    end else begin
      cmp_q <= cmp_in;
      done  <= fin;
      fin   <= wrap;
      if (accept) begin
        ramp_en <= 1'b1;
        cnt_bin <= '0;
      end else if (ramp_en) begin
        cnt_bin <= cnt_bin + 1'b1;
        if (wrap) ramp_en <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    localparam int BANK = i / CELLS_PER_BANK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_g[i] <= '0;
        ovf[i]    <= 1'b0;
        armed[i]  <= 1'b0;
      end else if (accept) begin
        if (bank_sel[BANK]) begin
          code_g[i] <= '0;
          ovf[i]    <= 1'b0;
          armed[i]  <= 1'b1;
        end
      end else if (ramp_en && armed[i]) begin
        if (rise[i]) begin
          code_g[i] <= gray_cnt;
          armed[i]  <= 1'b0;
        end else if (wrap) begin
          code_g[i] <= TOP ^ (TOP >> 1);
          ovf[i]    <= 1'b1;
          armed[i]  <= 1'b0;
        end
      end
    end

    assign code_bin[i*CNT_W +: CNT_W] = g2b(code_g[i]);

    assert_first_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ramp_en) && ramp_en && !$past(armed[i])) |-> $stable(code_bin[i*CNT_W +: CNT_W]))
      else $error("R7 cell %0d code changed after capture", i);

    assert_ovf_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[i] |-> (code_bin[i*CNT_W +: CNT_W] == TOP))
      else $error("R8 cell %0d overflow without max code", i);
  end

  assert_gray_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ramp_en) && ramp_en) |-> ($countones(gray_cnt ^ $past(gray_cnt)) == 1))
    else $error("R3 gray step not single-bit");

  assert_done_after_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en) |=> done)
    else $error("R4 done missing after ramp end");

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ramp_en && !$past(ramp_en)))
    else $error("R4 done during ramp");

  assert_ramp_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> $past(start))
    else $error("R5 ramp began without start");

endmodule

// File: tb/tb_wilk_conv_ctrl.sv
`timescale 1ns/1ps
module tb_wilk_conv_ctrl;
  localparam int W   = 10;
  localparam int NB  = 4;
  localparam int CPB = 4;
  localparam int NC  = NB * CPB;
  localparam int SPAN = 1 << W;
  localparam int NEVER = 5000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NB-1:0] bank_sel = '0;
  logic [NC-1:0] cmp_in = '0;
  logic ramp_en, done;
  logic [W-1:0] gray_cnt;
  logic [NC*W-1:0] code_bin;
  logic [NC-1:0] ovf;

  int checks = 0, errors = 0;
  int exp_code [NC];
  bit exp_ovf [NC];

  wilk_conv_ctrl #(.CNT_W(W), .NBANK(NB), .CELLS_PER_BANK(CPB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel), .cmp_in(cmp_in),
    .ramp_en(ramp_en), .done(done), .gray_cnt(gray_cnt), .code_bin(code_bin), .ovf(ovf));

  always #4 clk = ~clk;

  // pass vectors: mask in [15:12], seed in [11:0]
  localparam logic [15:0] VEC [6] = '{
    {4'b1111, 12'd3}, {4'b0101, 12'd17}, {4'b1010, 12'd29},
    {4'b0001, 12'd0}, {4'b1100, 12'd41}, {4'b1111, 12'd55}};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int fire_of(input int seed, input int i);
    int v;
    if (seed == 0) return NEVER;
    v = (seed * (i * 13 + 7)) % 1100;
    return (v >= SPAN) ? NEVER : v;
  endfunction

  task automatic run_pass(input logic [NB-1:0] mask, input int f [NC], input int mid,
                          input logic [NB-1:0] mid_mask);
    int bad_r = -1, bad_d = -1, bad_g = -1;
    @(negedge clk);
    cmp_in = '0; start = 1'b1; bank_sel = mask;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < SPAN + 4; c++) begin
      for (int i = 0; i < NC; i++)
        cmp_in[i] = (c >= f[i] && c < f[i] + 3) || (c >= f[i] + 8);
      start = (c == mid);
      if (c == mid) begin
        bank_sel = mid_mask;
        for (int i = 0; i < NC; i++)
          if (mask[i / CPB] && f[i] >= c && c < SPAN)
            chk(code_bin[i*W +: W] == 0, "R10 cleared before capture", int'(code_bin[i*W +: W]), 0);
      end
      if (bad_r < 0 && ramp_en != (c < SPAN)) bad_r = c;
      if (bad_d < 0 && done != (c == SPAN + 1)) bad_d = c;
      if (bad_g < 0 && gray_cnt != ((c < SPAN) ? W'(c ^ (c >> 1)) : W'(0))) bad_g = c;
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    chk(bad_r < 0, "R2/R5 ramp_en window", bad_r, -1);
    chk(bad_d < 0, "R4/R5 done pulse timing", bad_d, -1);
    chk(bad_g < 0, "R2/R3 gray count sequence", bad_g, -1);
    for (int i = 0; i < NC; i++) begin
      if (mask[i / CPB]) begin
        exp_code[i] = (f[i] < SPAN) ? f[i] : SPAN - 1;
        exp_ovf[i]  = (f[i] >= SPAN);
      end
      chk(int'(code_bin[i*W +: W]) == exp_code[i],
          mask[i / CPB] ? "R6/R7/R8 code" : "R9 retained code",
          int'(code_bin[i*W +: W]), exp_code[i]);
      chk(ovf[i] == exp_ovf[i], mask[i / CPB] ? "R8 ovf" : "R9 retained ovf",
          int'(ovf[i]), int'(exp_ovf[i]));
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f [NC];
    for (int i = 0; i < NC; i++) begin exp_code[i] = 0; exp_ovf[i] = 0; end
    repeat (3) @(negedge clk);
    chk(ramp_en == 0 && done == 0, "R1 reset controls", int'({ramp_en, done}), 0);
    chk(code_bin == '0 && ovf == '0 && gray_cnt == '0, "R1 reset outputs", int'(ovf), 0);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      for (int i = 0; i < NC; i++) f[i] = fire_of(int'(VEC[v][11:0]), i);
      run_pass(VEC[v][15:12], f, -1, '0);
    end

    // R11 last-count edge, first-count edge, never-firing cell
    for (int i = 0; i < NC; i++) f[i] = 100 + i;
    f[0] = 0; f[1] = SPAN - 1; f[2] = NEVER;
    run_pass(4'b0001, f, -1, '0);
    chk(int'(code_bin[1*W +: W]) == SPAN - 1 && ovf[1] == 0, "R11 last count capture",
        int'(ovf[1]), 0);

    // R5 start mid-ramp with a different mask
    for (int i = 0; i < NC; i++) f[i] = 300 + 40 * i;
    run_pass(4'b0011, f, 500, 4'b1100);

    // R5 start in the gap before done
    for (int i = 0; i < NC; i++) f[i] = 7 * i + 1;
    run_pass(4'b1000, f, SPAN, 4'b0111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule